// File: doc/BRIEF.md
# I2C Controller FIFO and Interrupt Unit

This unit sits between the host register bus of an I2C master controller and its bus engine. It holds two byte FIFOs: a transmit FIFO that the host fills by writing the TX data register and the engine drains through a pop handshake, and a receive FIFO that the engine fills through a push handshake and the host drains by reading the RX data register. Each FIFO has a 4-bit watermark and a flush control that takes a fixed number of cycles to complete.

FIFO levels and engine events feed an interrupt cause register. Level causes follow occupancy; event causes are sticky until the host writes ones to the clear register. A mask register selects the causes that drive the single registered interrupt line.

Register map (word index on `reg_addr`): 0 control (bit 7 TX flush, bit 8 RX flush), 1 TX data (write), 2 RX data (read pops), 3 TX watermark, 4 RX watermark, 5 mask, 6 raw status, 7 masked status, 8 clear (write-one-to-clear, reads 0). A read of any other index, or of the TX data register, returns 0.

Top module: `i2c_fifo_irq_unit`

## Requirements
- R1: After reset both FIFOs are empty, both watermarks and the mask are 0, no flush is running, `irq` is 0 and `raw_status` is 0x00000033 (bits 0, 1, 4, 5).
- R2: Each FIFO holds DEPTH (16) bytes and delivers them in arrival order: TX bytes at `eng_tx_data`, RX bytes at register 2, whose read data shows the oldest byte and whose read strobe removes it.
- R3: A host write to register 1 while the TX FIFO holds 16 bytes discards the byte and sets raw bit 3 (TX overrun) on the next clock.
- R4: `eng_tx_avail` is 1 exactly when the TX FIFO is non-empty and not flushing; `eng_rx_space` is 1 exactly when the RX FIFO holds fewer than 16 bytes and is not flushing; a pop or push outside these conditions has no effect.
- R5: Raw bit 0 (TX empty) is occupancy = 0, bit 1 (TX nearly empty) is occupancy <= TX watermark, bit 2 (TX full) is occupancy = 16.
- R6: Raw bit 4 (RX empty) is occupancy = 0, bit 5 (RX nearly full) is occupancy >= RX watermark, bit 6 (RX full) is occupancy = 16.
- R7: Writing 1 to control bit 7 (TX) or bit 8 (RX) starts a flush of that FIFO; the bit reads 1 for FLUSH_CYCLES (4) cycles, then reads 0 with the FIFO empty; host and engine accesses to that FIFO during the flush are ignored, and a flush request while one runs is ignored.
- R8: A one-cycle pulse on `ev_done`, `ev_done_nostop`, `ev_arb_lost`, `ev_bus_err` sets raw bit 19, 28, 24, 25 respectively, and the bit stays set until cleared.
- R9: Writing register 8 clears the sticky causes whose bits are one in both the written value and 0x131F007F; level bits (0, 1, 2, 4, 5, 6) are not affected, and a set in the same cycle wins over the clear.
- R10: The mask register stores bits 28..0 and reads bits 31..29 as 0; `masked_status` equals `raw_status` AND the mask.
- R11: `irq` equals the OR of `masked_status` one clock earlier.
- R12: The watermark registers keep only the low 4 bits written, so their values range 0 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RX FIFO at index 2) |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| eng_tx_pop | input | 1 | Engine takes the head TX byte |
| eng_tx_data | output | 8 | Head TX byte |
| eng_tx_avail | output | 1 | TX byte available to the engine |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_rx_space | output | 1 | RX FIFO can accept a byte |
| ev_done | input | 1 | Transfer finished with stop |
| ev_done_nostop | input | 1 | Transfer finished without stop |
| ev_arb_lost | input | 1 | Arbitration lost |
| ev_bus_err | input | 1 | Bus error |
| raw_status | output | 32 | Raw interrupt causes |
| masked_status | output | 32 | Raw causes AND mask |
| irq | output | 1 | Registered interrupt line |

## Verification
The hardest corners to reach are a flush racing with traffic and the overrun at exactly 17 writes. The stimulus first fills the TX FIFO with 16 host writes and then adds one more. It also starts both flushes while the host and engine keep writing, popping and pushing, and again issues flush requests in the final flush cycle. A behavioural queue model compares every output on every cycle, so an access slipping through on the start or the last cycle of a flush is caught. Sticky causes are cleared in the same cycle as a new event pulse to show that the set wins.

// File: rtl/fiq_pkg.sv
// Shared constants for the I2C FIFO and interrupt unit: register indices,
// cause bit positions and the writable clear mask.
package fiq_pkg;
    localparam int ADDR_W = 4;
    localparam int REG_W  = 32;

    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] A_TXD    = 4'd1;
    localparam logic [ADDR_W-1:0] A_RXD    = 4'd2;
    localparam logic [ADDR_W-1:0] A_TXWM   = 4'd3;
    localparam logic [ADDR_W-1:0] A_RXWM   = 4'd4;
    localparam logic [ADDR_W-1:0] A_MASK   = 4'd5;
    localparam logic [ADDR_W-1:0] A_RAW    = 4'd6;
    localparam logic [ADDR_W-1:0] A_MASKED = 4'd7;
    localparam logic [ADDR_W-1:0] A_CLR    = 4'd8;

    localparam int CTL_FLUSH_TX = 7;
    localparam int CTL_FLUSH_RX = 8;

    localparam int C_TX_EMPTY  = 0;
    localparam int C_TX_NEMPTY = 1;
    localparam int C_TX_FULL   = 2;
    localparam int C_TX_OVR    = 3;
    localparam int C_RX_EMPTY  = 4;
    localparam int C_RX_NFULL  = 5;
    localparam int C_RX_FULL   = 6;
    localparam int C_DONE      = 19;
    localparam int C_ARB       = 24;
    localparam int C_BERR      = 25;
    localparam int C_DONE_NS   = 28;

    localparam int MASK_W = 29;
    localparam logic [REG_W-1:0] CLR_ALLOWED = 32'h131F_007F;
endpackage

// File: rtl/fiq_flush_timer.sv
// Flush sequencer: a start while idle makes busy high for CYCLES cycles;
// done pulses in the last busy cycle. Assumes CYCLES >= 1.
module fiq_flush_timer #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] left;

    // Count down the flush duration; requests during a flush are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            left <= '0;
        end else if (busy) begin
            if (left == '0) busy <= 1'b0;
            else            left <= left - 1'b1;
        end else if (start) begin
            busy <= 1'b1;
            left <= CNT_W'(CYCLES - 1);
        end
    end

    assign done = busy && (left == '0);
endmodule

// File: rtl/fiq_fifo.sv
// Byte FIFO with a timed flush. Push when full, pop when empty, and any
// access while flushing are ignored. Occupancy drops to zero at flush end.
// Assumes DEPTH is a power of two.
module fiq_fifo #(
    parameter int DEPTH        = 16,
    parameter int DATA_W       = 8,
    parameter int FLUSH_CYCLES = 4,
    localparam int PTR_W       = $clog2(DEPTH),
    localparam int CNT_W       = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_req,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic              flushing
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr, rptr;
    logic              flush_done;
    logic              push_ok, pop_ok;

    fiq_flush_timer #(.CYCLES(FLUSH_CYCLES)) u_flush (
        .clk   (clk),
        .rst_n (rst_n),
        .start (flush_req),
        .busy  (flushing),
        .done  (flush_done)
    );

    assign push_ok = push && (count != CNT_W'(DEPTH)) && !flushing;
    assign pop_ok  = pop && (count != '0) && !flushing;

    // Store an accepted byte at the write pointer.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= push_data;
    end

    // Track pointers and occupancy; flush completion empties the FIFO.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_done) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) wptr <= wptr + 1'b1;
            if (pop_ok)  rptr <= rptr + 1'b1;
            count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

    assign head = mem[rptr];
endmodule

// File: rtl/fiq_irq_regs.sv
// Interrupt cause register set: level causes pass through, event causes
// are sticky with write-one-to-clear (set wins), mask of MASK_W bits,
// and a registered interrupt line.
module fiq_irq_regs
    import fiq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] level,
    input  logic [REG_W-1:0] set_ev,
    input  logic             clr_wr,
    input  logic             mask_wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] raw,
    output logic [REG_W-1:0] mask_rd,
    output logic [REG_W-1:0] masked,
    output logic             irq
);
    logic [REG_W-1:0]  sticky;
    logic [REG_W-1:0]  clr_bits;
    logic [MASK_W-1:0] mask_q;

    assign clr_bits = clr_wr ? (wdata & CLR_ALLOWED) : '0;

    // Hold event causes until cleared; a new event overrides the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) sticky <= '0;
        else        sticky <= (sticky & ~clr_bits) | set_ev;
    end

    // Keep the writable part of the mask.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= wdata[MASK_W-1:0];
    end

    assign raw     = level | sticky;
    assign mask_rd = {{(REG_W-MASK_W){1'b0}}, mask_q};
    assign masked  = raw & mask_rd;

    // Register the OR of the enabled causes.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |masked;
    end
endmodule

// File: rtl/i2c_fifo_irq_unit.sv
// Top of the I2C FIFO and interrupt unit: register decode, two byte FIFOs
// with watermarks, and the cause/mask register set. Register reads are
// combinational; a read strobe at the RX data index pops one byte.
module i2c_fifo_irq_unit
    import fiq_pkg::*;
#(
    parameter int DEPTH        = 16,
    parameter int DATA_W       = 8,
    parameter int WM_W         = 4,
    parameter int FLUSH_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              eng_tx_pop,
    output logic [DATA_W-1:0] eng_tx_data,
    output logic              eng_tx_avail,
    input  logic              eng_rx_push,
    input  logic [DATA_W-1:0] eng_rx_data,
    output logic              eng_rx_space,
    input  logic              ev_done,
    input  logic              ev_done_nostop,
    input  logic              ev_arb_lost,
    input  logic              ev_bus_err,
    output logic [REG_W-1:0]  raw_status,
    output logic [REG_W-1:0]  masked_status,
    output logic              irq
);
    localparam int CNT_W = $clog2(DEPTH) + 1;

    logic [CNT_W-1:0]  tx_cnt, rx_cnt;
    logic [DATA_W-1:0] rx_head;
    logic              tx_flushing, rx_flushing;
    logic [WM_W-1:0]   tx_wm, rx_wm;
    logic              tx_full, rx_full, tx_empty, rx_empty;
    logic              wr_txd, wr_ctrl, rd_rxd;
    logic [REG_W-1:0]  level, set_ev, mask_rd;

    assign wr_txd  = reg_wr && (reg_addr == A_TXD);
    assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    assign rd_rxd  = reg_rd && (reg_addr == A_RXD);

    fiq_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W), .FLUSH_CYCLES(FLUSH_CYCLES)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_req (wr_ctrl && reg_wdata[CTL_FLUSH_TX]),
        .push      (wr_txd),
        .push_data (reg_wdata[DATA_W-1:0]),
        .pop       (eng_tx_pop),
        .head      (eng_tx_data),
        .count     (tx_cnt),
        .flushing  (tx_flushing)
    );

    fiq_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W), .FLUSH_CYCLES(FLUSH_CYCLES)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_req (wr_ctrl && reg_wdata[CTL_FLUSH_RX]),
        .push      (eng_rx_push),
        .push_data (eng_rx_data),
        .pop       (rd_rxd),
        .head      (rx_head),
        .count     (rx_cnt),
        .flushing  (rx_flushing)
    );

    // Watermark registers, low WM_W bits of the written value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_wm <= '0;
            rx_wm <= '0;
        end else if (reg_wr) begin
            if (reg_addr == A_TXWM) tx_wm <= reg_wdata[WM_W-1:0];
            if (reg_addr == A_RXWM) rx_wm <= reg_wdata[WM_W-1:0];
        end
    end

    assign tx_full  = (tx_cnt == CNT_W'(DEPTH));
    assign rx_full  = (rx_cnt == CNT_W'(DEPTH));
    assign tx_empty = (tx_cnt == '0);
    assign rx_empty = (rx_cnt == '0);

    assign eng_tx_avail = !tx_empty && !tx_flushing;
    assign eng_rx_space = !rx_full && !rx_flushing;

    // Place occupancy levels and event pulses at their cause positions.
    always_comb begin
        level = '0;
        level[C_TX_EMPTY]  = tx_empty;
        level[C_TX_NEMPTY] = (tx_cnt <= CNT_W'(tx_wm));
        level[C_TX_FULL]   = tx_full;
        level[C_RX_EMPTY]  = rx_empty;
        level[C_RX_NFULL]  = (rx_cnt >= CNT_W'(rx_wm));
        level[C_RX_FULL]   = rx_full;
        set_ev = '0;
        set_ev[C_TX_OVR]   = wr_txd && tx_full;
        set_ev[C_DONE]     = ev_done;
        set_ev[C_DONE_NS]  = ev_done_nostop;
        set_ev[C_ARB]      = ev_arb_lost;
        set_ev[C_BERR]     = ev_bus_err;
    end

    fiq_irq_regs u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .level   (level),
        .set_ev  (set_ev),
        .clr_wr  (reg_wr && (reg_addr == A_CLR)),
        .mask_wr (reg_wr && (reg_addr == A_MASK)),
        .wdata   (reg_wdata),
        .raw     (raw_status),
        .mask_rd (mask_rd),
        .masked  (masked_status),
        .irq     (irq)
    );

    // Register read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[CTL_FLUSH_TX] = tx_flushing;
                reg_rdata[CTL_FLUSH_RX] = rx_flushing;
            end
            A_RXD:    reg_rdata[DATA_W-1:0] = rx_empty ? '0 : rx_head;
            A_TXWM:   reg_rdata[WM_W-1:0]   = tx_wm;
            A_RXWM:   reg_rdata[WM_W-1:0]   = rx_wm;
            A_MASK:   reg_rdata = mask_rd;
            A_RAW:    reg_rdata = raw_status;
            A_MASKED: reg_rdata = masked_status;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/fiq_checker.sv
// Assertion checker for i2c_fifo_irq_unit, attached by bind below.
// Assumes reset is held for at least two clocks.
module fiq_checker
    import fiq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              wdata_b24,
    input logic [REG_W-1:0]  raw_status,
    input logic [REG_W-1:0]  masked_status,
    input logic              irq,
    input logic              eng_tx_avail,
    input logic              eng_rx_space,
    input logic              tx_flushing
);
    p_irq_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(|masked_status));

    p_masked_subset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (masked_status & ~raw_status) == '0);

    p_overrun_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_TXD && raw_status[C_TX_FULL]) |=> raw_status[C_TX_OVR]);

    p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_status[C_ARB] && !(reg_wr && reg_addr == A_CLR && wdata_b24)) |=> raw_status[C_ARB]);

    p_no_pop_in_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flushing |-> !eng_tx_avail);

    p_full_no_space_r4: assert property (@(posedge clk) disable iff (!rst_n)
        raw_status[C_RX_FULL] |-> !eng_rx_space);

    p_empty_full_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(raw_status[C_TX_EMPTY] && raw_status[C_TX_FULL]));
endmodule

bind i2c_fifo_irq_unit fiq_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .wdata_b24     (reg_wdata[24]),
    .raw_status    (raw_status),
    .masked_status (masked_status),
    .irq           (irq),
    .eng_tx_avail  (eng_tx_avail),
    .eng_rx_space  (eng_rx_space),
    .tx_flushing   (tx_flushing)
);

// File: tb/tb_i2c_fifo_irq_unit.sv
// Bench: behavioural queue model updated at each rising edge and compared
// with every output 2 ns after each falling edge, plus directed checks.
module tb_i2c_fifo_irq_unit;
    localparam int FLUSH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        eng_tx_pop = 1'b0, eng_tx_avail, eng_rx_push = 1'b0, eng_rx_space;
    logic [7:0]  eng_tx_data, eng_rx_data = '0;
    logic        ev_done = 1'b0, ev_done_nostop = 1'b0, ev_arb_lost = 1'b0, ev_bus_err = 1'b0;
    logic [31:0] raw_status, masked_status;
    logic        irq;

    i2c_fifo_irq_unit dut (.*);

    always #5 clk = ~clk;

    // Reference model state
    logic [7:0]  txq[$], rxq[$];
    logic [3:0]  m_txwm, m_rxwm;
    logic [31:0] m_mask, m_sticky;
    logic        m_irq;
    int          m_txfl, m_rxfl;
    int          n_checks = 0, n_fail = 0;
    bit          finished = 0;

    function automatic logic [31:0] m_raw();
        logic [31:0] r = m_sticky;
        r[0] = (txq.size() == 0);
        r[1] = (txq.size() <= int'(m_txwm));
        r[2] = (txq.size() == 16);
        r[4] = (rxq.size() == 0);
        r[5] = (rxq.size() >= int'(m_rxwm));
        r[6] = (rxq.size() == 16);
        return r;
    endfunction

    function automatic logic [31:0] m_rdata();
        case (reg_addr)
            4'd0: return {23'd0, m_rxfl > 0, m_txfl > 0, 7'd0};
            4'd2: return (rxq.size() > 0) ? {24'd0, rxq[0]} : 32'd0;
            4'd3: return {28'd0, m_txwm};
            4'd4: return {28'd0, m_rxwm};
            4'd5: return m_mask;
            4'd6: return m_raw();
            4'd7: return m_raw() & m_mask;
            default: return 32'd0;
        endcase
    endfunction

    // Model update at each rising edge, from the inputs held since the falling edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            txq.delete(); rxq.delete();
            m_txwm = 0; m_rxwm = 0; m_mask = 0; m_sticky = 0; m_irq = 0;
            m_txfl = 0; m_rxfl = 0;
        end else begin
            logic [31:0] raw_b, clr, setv;
            int tsz, rsz;
            bit tfl, rfl;
            raw_b = m_raw();
            m_irq = |(raw_b & m_mask);
            tsz = txq.size(); rsz = rxq.size();
            tfl = m_txfl > 0; rfl = m_rxfl > 0;
            setv = 0;
            if (reg_wr && reg_addr == 4'd1 && tsz == 16) setv[3] = 1;
            setv[19] = ev_done; setv[28] = ev_done_nostop;
            setv[24] = ev_arb_lost; setv[25] = ev_bus_err;
            clr = (reg_wr && reg_addr == 4'd8) ? (reg_wdata & 32'h131F007F) : 32'd0;
            m_sticky = (m_sticky & ~clr) | setv;
            if (eng_tx_pop && !tfl && tsz > 0) void'(txq.pop_front());
            if (reg_wr && reg_addr == 4'd1 && !tfl && tsz < 16) txq.push_back(reg_wdata[7:0]);
            if (reg_rd && reg_addr == 4'd2 && !rfl && rsz > 0) void'(rxq.pop_front());
            if (eng_rx_push && !rfl && rsz < 16) rxq.push_back(eng_rx_data);
            if (m_txfl > 0) begin
                if (m_txfl == 1) txq.delete();
                m_txfl--;
            end else if (reg_wr && reg_addr == 4'd0 && reg_wdata[7]) m_txfl = FLUSH;
            if (m_rxfl > 0) begin
                if (m_rxfl == 1) rxq.delete();
                m_rxfl--;
            end else if (reg_wr && reg_addr == 4'd0 && reg_wdata[8]) m_rxfl = FLUSH;
            if (reg_wr && reg_addr == 4'd5) m_mask = reg_wdata & 32'h1FFFFFFF;
            if (reg_wr && reg_addr == 4'd3) m_txwm = reg_wdata[3:0];
            if (reg_wr && reg_addr == 4'd4) m_rxwm = reg_wdata[3:0];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output with the model, then advance one clock.
    task automatic cyc();
        #2;
        if (rst_n) begin
            chk("R5 R6 R8 R9 raw_status", raw_status, m_raw());
            chk("R10 masked_status", masked_status, m_raw() & m_mask);
            chk("R11 irq", {31'd0, irq}, {31'd0, m_irq});
            chk("R4 eng_tx_avail", {31'd0, eng_tx_avail}, {31'd0, txq.size() > 0 && m_txfl == 0});
            chk("R4 eng_rx_space", {31'd0, eng_rx_space}, {31'd0, rxq.size() < 16 && m_rxfl == 0});
            if (eng_tx_avail) chk("R2 eng_tx_data", {24'd0, eng_tx_data}, {24'd0, txq[0]});
            chk("R2 R7 R12 reg_rdata", reg_rdata, m_rdata());
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        reg_wr = 0; reg_rd = 0; eng_tx_pop = 0; eng_rx_push = 0;
        ev_done = 0; ev_done_nostop = 0; ev_arb_lost = 0; ev_bus_err = 0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        idle(); reg_wr = 1; reg_addr = a; reg_wdata = d; cyc(); idle();
    endtask

    task automatic look(input logic [3:0] a);
        idle(); reg_addr = a; #1;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        // R1 reset state
        look(4'd6); chk("R1 reset raw", reg_rdata, 32'h0000_0033);
        chk("R1 reset irq", {31'd0, irq}, 32'd0);
        look(4'd5); chk("R1 reset mask", reg_rdata, 32'd0);
        cyc();

        // R12 watermark width, R10 mask reserved bits
        wr(4'd3, 32'h1F); look(4'd3); chk("R12 txwm readback", reg_rdata, 32'hF); cyc();
        wr(4'd3, 32'h3);  wr(4'd4, 32'h5);
        wr(4'd5, 32'hFFFF_FFFF); look(4'd5); chk("R10 mask top bits", reg_rdata, 32'h1FFF_FFFF); cyc();

        // R2 R5 fill TX to 16, then R3 overrun on the 17th
        for (int i = 0; i < 16; i++) wr(4'd1, i * 7 + 1);
        look(4'd6); chk("R5 tx full bit", {31'd0, reg_rdata[2]}, 32'd1); cyc();
        wr(4'd1, 32'hEE);
        look(4'd6); chk("R3 overrun bit", {31'd0, reg_rdata[3]}, 32'd1);
        chk("R3 head unchanged", {24'd0, eng_tx_data}, 32'd1); cyc();

        // R2 engine pops with simultaneous host writes
        for (int i = 0; i < 6; i++) begin
            idle(); eng_tx_pop = 1; if (i > 2) begin reg_wr = 1; reg_addr = 4'd1; reg_wdata = 32'h40 + i; end
            cyc();
        end
        idle();
        for (int i = 0; i < 14; i++) begin idle(); eng_tx_pop = 1; cyc(); end
        idle(); cyc();
        look(4'd6); chk("R4 pop on empty no effect", {31'd0, reg_rdata[0]}, 32'd1); cyc();

        // R6 fill RX to 16, push on full ignored, host reads
        for (int i = 0; i < 17; i++) begin idle(); eng_rx_push = 1; eng_rx_data = 8'hA0 + 8'(i); cyc(); end
        look(4'd2); chk("R2 rx head", reg_rdata, 32'hA0); cyc();
        for (int i = 0; i < 3; i++) begin idle(); reg_rd = 1; reg_addr = 4'd2; cyc(); end
        look(4'd2); chk("R2 rx order", reg_rdata, 32'hA3); cyc();

        // R7 flush both with traffic; requests again in the final flush cycle
        for (int i = 0; i < 4; i++) wr(4'd1, 32'h90 + i);
        wr(4'd0, 32'h180);
        look(4'd0); chk("R7 flush bits set", reg_rdata, 32'h180); cyc();
        for (int i = 0; i < FLUSH - 1; i++) begin
            idle(); eng_rx_push = 1; eng_tx_pop = 1; reg_wr = 1; reg_addr = (i == FLUSH - 2) ? 4'd0 : 4'd1;
            reg_wdata = (i == FLUSH - 2) ? 32'h180 : 32'h55; cyc();
        end
        idle(); look(4'd0); chk("R7 flush done", reg_rdata, 32'd0);
        look(4'd6); chk("R7 fifos empty", reg_rdata & 32'h11, 32'h11); cyc();
        wr(4'd1, 32'h77); wr(4'd1, 32'h78);
        idle(); eng_tx_pop = 1; cyc(); idle(); cyc();

        // R8 events, R9 clear with set-wins, R11 irq with a single mask bit
        wr(4'd5, 32'h0100_0000);
        idle(); ev_arb_lost = 1; ev_bus_err = 1; ev_done = 1; ev_done_nostop = 1; cyc(); idle();
        look(4'd6); chk("R8 event bits", reg_rdata & 32'h1308_0000, 32'h1308_0000); cyc();
        chk("R11 irq high", {31'd0, irq}, 32'd1);
        idle(); reg_wr = 1; reg_addr = 4'd8; reg_wdata = 32'hFFFF_FFFF; ev_done = 1; cyc(); idle();
        look(4'd6); chk("R9 clear and set wins", reg_rdata & 32'h1308_0008, 32'h0008_0000);
        chk("R9 level bits kept", reg_rdata & 32'h77, m_raw() & 32'h77); cyc();
        cyc();
        chk("R11 irq low", {31'd0, irq}, 32'd0);
        wr(4'd8, 32'h0008_0000);
        repeat (4) cyc();
        finish_run();
    end
endmodule